// File: doc/BRIEF.md
# SD Multi-Sector Read Sequencer (SPI mode)

This block fetches a run of consecutive 512-byte sectors from an SD card that runs in SPI mode. A host gives it a first sector number, a sector count and a one-cycle start pulse. The block then drives the card through a byte-exchange port and chip select. The payload comes back as a byte stream with valid and last strobes. A done pulse ends each request and carries an error level.

The block picks between two ways to end a multi-sector read. In the counted way it announces the sector count with CMD23 before CMD18, and the card stops by itself. In the open-ended way it sends CMD18 alone and ends the transfer with CMD12. The block does not trust what the card registers claim about CMD23. It tries CMD23 on live traffic and, when the card rejects it, records that fact in a sticky warning bit and uses the open-ended way from then on. It also handles a card that is already streaming the next sector when the stop command arrives: it drops chip select briefly and resynchronises instead of failing. Each sector is checked with CRC16, and every completed read ends with a CMD13 status poll.

Top module: `sdrd_seq`

## Requirements
- R1: After reset, cs_n is 1, busy is 0, warnings is 2'b00, and xfer_req and rd_valid are 0. While the block is idle, cs_n stays 1.
- R2: Each command is sent with cs_n low as one 0xFF spacer byte followed by six bytes: 0x40 OR the command index, the 32-bit argument most significant byte first, and the trailer byte 0x01.
- R3: In a command response, bytes with bit 7 set are skipped, up to 8 polls. The first byte with bit 7 clear is R1. After CMD12, one stuff byte is discarded before polling starts. If no R1 arrives after CMD23, CMD18 or CMD13, the read ends with err set.
- R4: When CMD23 is not disabled, a read of N sectors sends CMD23 with argument N and then CMD18 with the start sector. An R1 of 0x00 to CMD23 selects counted mode. In counted mode exactly N sectors are read, no CMD12 is sent, and CMD13 follows.
- R5: An R1 to CMD23 with bit 2 (illegal command) set sets warnings[0]. warnings[0] stays set until reset. The same read carries on with CMD18 and ends with CMD12, and later reads skip CMD23.
- R6: Each sector's 512 data bytes appear on rd_data in card order, one per rd_valid cycle. rd_last is high only with the final byte of the final requested sector.
- R7: Before each sector, 0xFF bytes are skipped while waiting for the 0xFE start token, for up to TOKEN_TRIES bytes. Any other byte, or running out of tries, sets err and sends CMD12.
- R8: The two bytes after each payload are its CRC16 (polynomial 0x1021, initial value 0, most significant byte first). On a mismatch, err is set, CMD12 is sent and no further sector is read.
- R9: If CMD12 gets a nonzero R1 or no R1, cs_n goes high for RESYNC_BYTES bytes and warnings[1] is set. This is not an error, and CMD13 follows when no earlier error occurred.
- R10: CMD13 must return R1 0x00 followed by a 0x00 status byte. Any other value sets err.
- R11: A start with sector_count 0 gives done on the next cycle, with err 0 and no byte traffic.
- R12: A start pulse while busy is ignored.
- R13: done is a one-cycle pulse in the first idle cycle. err holds the result of the last read until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request pulse |
| start_sector | input | SECT_W | First sector number (block addressing) |
| sector_count | input | CNT_W | Number of sectors to read |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Result of the last request |
| warnings | output | 2 | Bit 0: CMD23 rejected (sticky); bit 1: stop recovery used |
| rd_data | output | 8 | Sector payload byte |
| rd_valid | output | 1 | rd_data is valid |
| rd_last | output | 1 | Final byte of the request |
| cs_n | output | 1 | Card chip select, active low |
| xfer_req | output | 1 | Byte exchange request to the SPI shifter |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Exchange finished, one-cycle pulse |
| xfer_rx | input | 8 | Byte received during the exchange |

## Verification
The card model makes the turnaround delay 7 filler bytes, which fits inside the poll limit, and then 8, which does not. A sequencer that miscounted the poll limit would either time out on a healthy card or hang on a silent one. A second card model rejects CMD23 and then keeps streaming through CMD12. A design without the sticky flag would resend CMD23 on the following read. A design without resynchronisation would report failure where the command log expects a recovered stop followed by CMD13. Corrupted CRC, a missing start token and a nonzero CMD13 status each have to cut the command sequence short at the right point and raise err, without emitting rd_last too early.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_SETCNT, SQ_RDCMD, SQ_TOKEN, SQ_DATA,
    SQ_CRCH, SQ_CRCL, SQ_STOP, SQ_RESYNC, SQ_STATUS
  } seq_state_t;

  typedef enum logic [2:0] {
    CE_IDLE, CE_PAD, CE_FRAME, CE_STUFF, CE_POLL, CE_EXTRA, CE_FIN
  } cmd_state_t;

  localparam logic [5:0] IDX_STOP    = 6'd12;
  localparam logic [5:0] IDX_STATUS  = 6'd13;
  localparam logic [5:0] IDX_RDMULTI = 6'd18;
  localparam logic [5:0] IDX_SETCNT  = 6'd23;
  localparam logic [7:0] IDLE_BYTE   = 8'hFF;
  localparam logic [7:0] START_TOKEN = 8'hFE;

  // CRC16 with polynomial 0x1021, one byte folded in at a time
  function automatic logic [15:0] crc16_byte(logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int b = 0; b < 8; b++) begin
      r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    end
    return r;
  endfunction

  // k-th byte of a six-byte command frame
  function automatic logic [7:0] frame_byte(logic [5:0] idx, logic [31:0] arg, logic [2:0] k);
    case (k)
      3'd0:    return {2'b01, idx};
      3'd1:    return arg[31:24];
      3'd2:    return arg[23:16];
      3'd3:    return arg[15:8];
      3'd4:    return arg[7:0];
      default: return 8'h01;
    endcase
  endfunction

  function automatic logic r1_illegal(logic [7:0] r1);
    return r1[2];
  endfunction

endpackage

// File: rtl/sdrd_crc.sv
module sdrd_crc
  import sdrd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  d,
  output logic [15:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= crc16_byte(crc, d);
  end
endmodule

// File: rtl/sdrd_cmd.sv
module sdrd_cmd
  import sdrd_pkg::*;
#(
  parameter int NCR_MAX = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  input  logic        skip_stuff,
  input  logic        want_r2,
  output logic        b_req,
  output logic [7:0]  b_tx,
  input  logic        b_ack,
  input  logic [7:0]  b_rx,
  output logic        fin,
  output logic [7:0]  r1,
  output logic [7:0]  r2,
  output logic        tmo
);
  localparam int PW = $clog2(NCR_MAX + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(NCR_MAX - 1);

  cmd_state_t    st;
  logic [2:0]    k;
  logic [PW-1:0] polls;
  logic [5:0]    idx_q;
  logic [31:0]   arg_q;
  logic          skip_q, r2_q;

  always_comb begin
    b_req = (st != CE_IDLE) && (st != CE_FIN);
    b_tx  = (st == CE_FRAME) ? frame_byte(idx_q, arg_q, k) : IDLE_BYTE;
  end

  assign fin = (st == CE_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= CE_IDLE; k <= '0; polls <= '0; idx_q <= '0; arg_q <= '0;
      skip_q <= 1'b0; r2_q <= 1'b0; r1 <= 8'hFF; r2 <= 8'hFF; tmo <= 1'b0;
    end else begin
      case (st)
        CE_IDLE: if (go) begin
          idx_q <= idx; arg_q <= arg; skip_q <= skip_stuff; r2_q <= want_r2;
          tmo <= 1'b0; r1 <= 8'hFF; r2 <= 8'hFF; st <= CE_PAD;
        end
        CE_PAD: if (b_ack) begin
          k <= '0; st <= CE_FRAME;
        end
        CE_FRAME: if (b_ack) begin
          if (k == 3'd5) begin
            polls <= '0;
            st <= skip_q ? CE_STUFF : CE_POLL;
          end else k <= k + 3'd1;
        end
        CE_STUFF: if (b_ack) st <= CE_POLL;
        CE_POLL: if (b_ack) begin
          if (!b_rx[7]) begin
            r1 <= b_rx;
            st <= r2_q ? CE_EXTRA : CE_FIN;
          end else if (polls == POLL_LAST) begin
            tmo <= 1'b1; st <= CE_FIN;
          end else polls <= polls + 1'b1;
        end
        CE_EXTRA: if (b_ack) begin
          r2 <= b_rx; st <= CE_FIN;
        end
        default: st <= CE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdrd_seq.sv
module sdrd_seq
  import sdrd_pkg::*;
#(
  parameter int SECT_W       = 32,
  parameter int CNT_W        = 16,
  parameter int BLK_BYTES    = 512,
  parameter int NCR_MAX      = 8,
  parameter int TOKEN_TRIES  = 1024,
  parameter int RESYNC_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SECT_W-1:0] start_sector,
  input  logic [CNT_W-1:0]  sector_count,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        warnings,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              rd_last,
  output logic              cs_n,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx
);
  localparam int BW = $clog2(BLK_BYTES);
  localparam int TW = $clog2(TOKEN_TRIES);
  localparam int RW = (RESYNC_BYTES > 1) ? $clog2(RESYNC_BYTES) : 1;
  localparam logic [BW-1:0]    BYTE_LAST = BW'(BLK_BYTES - 1);
  localparam logic [TW-1:0]    TRY_LAST  = TW'(TOKEN_TRIES - 1);
  localparam logic [RW-1:0]    RS_LAST   = RW'(RESYNC_BYTES - 1);
  localparam logic [CNT_W-1:0] ONE_LEFT  = CNT_W'(1);

  seq_state_t        st;
  logic              issued, pre_mode, err_q, done_q, cs_q;
  logic [1:0]        warn_q;
  logic [CNT_W-1:0]  left, cnt_q;
  logic [SECT_W-1:0] sect_q;
  logic [BW-1:0]     bcnt;
  logic [TW-1:0]     tries;
  logic [RW-1:0]     rs_cnt;
  logic [7:0]        crc_hi;

  // command engine hookup
  logic        cmd_phase, cmd_go, c_req, c_ack, c_fin, c_tmo, c_skip, c_want2, c_bad;
  logic [7:0]  c_tx, c_r1, c_r2;
  logic [5:0]  c_idx;
  logic [31:0] c_arg;
  logic        s_req, s_ack;
  logic [15:0] crc_now;
  logic        crc_clr, crc_en;

  // named internal events, observed by the checker
  logic ev_reject23, ev_recover, ev_crc_bad, ev_token_ok;

  assign cmd_phase = (st == SQ_SETCNT) || (st == SQ_RDCMD) || (st == SQ_STOP) || (st == SQ_STATUS);
  assign s_req     = (st == SQ_TOKEN) || (st == SQ_DATA) || (st == SQ_CRCH) ||
                     (st == SQ_CRCL) || (st == SQ_RESYNC);
  assign xfer_req  = cmd_phase ? c_req : s_req;
  assign xfer_tx   = cmd_phase ? c_tx : IDLE_BYTE;
  assign c_ack     = cmd_phase & xfer_ack;
  assign s_ack     = s_req & xfer_ack;
  assign cmd_go    = cmd_phase & ~issued;
  assign c_bad     = c_tmo | (c_r1 != 8'h00);

  always_comb begin
    c_idx = IDX_STATUS; c_arg = '0; c_skip = 1'b0; c_want2 = 1'b0;
    case (st)
      SQ_SETCNT: begin c_idx = IDX_SETCNT;  c_arg = 32'(cnt_q); end
      SQ_RDCMD:  begin c_idx = IDX_RDMULTI; c_arg = 32'(sect_q); end
      SQ_STOP:   begin c_idx = IDX_STOP;    c_skip = 1'b1; end
      SQ_STATUS: begin c_idx = IDX_STATUS;  c_want2 = 1'b1; end
      default: ;
    endcase
  end

  assign ev_token_ok = (st == SQ_TOKEN) && s_ack && (xfer_rx == START_TOKEN);
  assign ev_reject23 = (st == SQ_SETCNT) && c_fin && !c_tmo && (c_r1 != 8'h00) && r1_illegal(c_r1);
  assign ev_recover  = (st == SQ_STOP) && c_fin && c_bad;
  assign ev_crc_bad  = (st == SQ_CRCL) && s_ack && ({crc_hi, xfer_rx} != crc_now);
  assign crc_clr     = ev_token_ok;
  assign crc_en      = (st == SQ_DATA) && s_ack;

  sdrd_cmd #(.NCR_MAX(NCR_MAX)) u_cmd (
    .clk(clk), .rst_n(rst_n), .go(cmd_go), .idx(c_idx), .arg(c_arg),
    .skip_stuff(c_skip), .want_r2(c_want2),
    .b_req(c_req), .b_tx(c_tx), .b_ack(c_ack), .b_rx(xfer_rx),
    .fin(c_fin), .r1(c_r1), .r2(c_r2), .tmo(c_tmo)
  );

  sdrd_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .d(xfer_rx), .crc(crc_now)
  );

  assign busy     = (st != SQ_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign warnings = warn_q;
  assign cs_n     = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; issued <= 1'b0; pre_mode <= 1'b0; err_q <= 1'b0; done_q <= 1'b0;
      cs_q <= 1'b1; warn_q <= 2'b00; left <= '0; cnt_q <= '0; sect_q <= '0;
      bcnt <= '0; tries <= '0; rs_cnt <= '0; crc_hi <= '0;
      rd_data <= '0; rd_valid <= 1'b0; rd_last <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      if (cmd_go) issued <= 1'b1;
      if (c_fin)  issued <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          err_q <= 1'b0;
          if (sector_count == '0) begin
            done_q <= 1'b1;
          end else begin
            cs_q <= 1'b0; sect_q <= start_sector; cnt_q <= sector_count;
            left <= sector_count; pre_mode <= 1'b0;
            st <= warn_q[0] ? SQ_RDCMD : SQ_SETCNT;
          end
        end
        SQ_SETCNT: if (c_fin) begin
          if (c_tmo) begin
            err_q <= 1'b1; cs_q <= 1'b1; done_q <= 1'b1; st <= SQ_IDLE;
          end else if (c_r1 == 8'h00) begin
            pre_mode <= 1'b1; st <= SQ_RDCMD;
          end else if (r1_illegal(c_r1)) begin
            warn_q[0] <= 1'b1; st <= SQ_RDCMD;
          end else begin
            err_q <= 1'b1; cs_q <= 1'b1; done_q <= 1'b1; st <= SQ_IDLE;
          end
        end
        SQ_RDCMD: if (c_fin) begin
          if (c_bad) begin
            err_q <= 1'b1; cs_q <= 1'b1; done_q <= 1'b1; st <= SQ_IDLE;
          end else begin
            tries <= '0; st <= SQ_TOKEN;
          end
        end
        SQ_TOKEN: if (s_ack) begin
          if (xfer_rx == START_TOKEN) begin
            bcnt <= '0; st <= SQ_DATA;
          end else if (xfer_rx == IDLE_BYTE && tries != TRY_LAST) begin
            tries <= tries + 1'b1;
          end else begin
            err_q <= 1'b1; st <= SQ_STOP;
          end
        end
        SQ_DATA: if (s_ack) begin
          rd_data  <= xfer_rx;
          rd_valid <= 1'b1;
          rd_last  <= (left == ONE_LEFT) && (bcnt == BYTE_LAST);
          bcnt     <= bcnt + 1'b1;
          if (bcnt == BYTE_LAST) st <= SQ_CRCH;
        end
        SQ_CRCH: if (s_ack) begin
          crc_hi <= xfer_rx; st <= SQ_CRCL;
        end
        SQ_CRCL: if (s_ack) begin
          if (ev_crc_bad) begin
            err_q <= 1'b1; st <= SQ_STOP;
          end else if (left == ONE_LEFT) begin
            st <= pre_mode ? SQ_STATUS : SQ_STOP;
          end else begin
            left <= left - 1'b1; tries <= '0; st <= SQ_TOKEN;
          end
        end
        SQ_STOP: if (c_fin) begin
          if (c_bad) begin
            warn_q[1] <= 1'b1; cs_q <= 1'b1; rs_cnt <= '0; st <= SQ_RESYNC;
          end else if (err_q) begin
            cs_q <= 1'b1; done_q <= 1'b1; st <= SQ_IDLE;
          end else st <= SQ_STATUS;
        end
        SQ_RESYNC: if (s_ack) begin
          if (rs_cnt == RS_LAST) begin
            if (err_q) begin
              done_q <= 1'b1; st <= SQ_IDLE;
            end else begin
              cs_q <= 1'b0; st <= SQ_STATUS;
            end
          end else rs_cnt <= rs_cnt + 1'b1;
        end
        SQ_STATUS: if (c_fin) begin
          if (c_bad || c_r2 != 8'h00) err_q <= 1'b1;
          cs_q <= 1'b1; done_q <= 1'b1; st <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdrd_seq_chk.sv
module sdrd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [1:0] warnings,
  input logic       rd_valid,
  input logic       rd_last,
  input logic       cs_n,
  input logic       xfer_req,
  input logic       ev_reject23,
  input logic       ev_recover,
  input logic       ev_crc_bad
);
  assert_idle_cs_R1: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);
  assert_no_req_idle_R12: assert property (@(posedge clk) disable iff (!rst_n) xfer_req |-> busy);
  assert_reject_flag_R5: assert property (@(posedge clk) disable iff (!rst_n) ev_reject23 |=> warnings[0]);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n) warnings[0] |=> warnings[0]);
  assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n) rd_last |-> rd_valid);
  assert_valid_selected_R6: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> !cs_n);
  assert_crc_err_R8: assert property (@(posedge clk) disable iff (!rst_n) ev_crc_bad |=> err);
  assert_recover_flag_R9: assert property (@(posedge clk) disable iff (!rst_n) ev_recover |=> warnings[1]);
  assert_done_idle_R13: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  assert_fall_done_R13: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
endmodule

bind sdrd_seq sdrd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err), .warnings(warnings),
  .rd_valid(rd_valid), .rd_last(rd_last), .cs_n(cs_n), .xfer_req(xfer_req),
  .ev_reject23(ev_reject23), .ev_recover(ev_recover), .ev_crc_bad(ev_crc_bad)
);

// File: tb/sdrd_seq_tb.sv
module sdrd_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_sector = '0;
  logic [15:0] sector_count = '0;
  logic        busy, done, err, rd_valid, rd_last, cs_n, xfer_req;
  logic [1:0]  warnings;
  logic [7:0]  rd_data, xfer_tx;
  logic        xfer_ack = 1'b0;
  logic [7:0]  xfer_rx = 8'hFF;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sdrd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_sector(start_sector),
    .sector_count(sector_count), .busy(busy), .done(done), .err(err), .warnings(warnings),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last), .cs_n(cs_n),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- card model configuration ----------------
  int          c_ncr = 3;
  bit          c_rej23 = 0;
  bit          c_mute = 0;
  bit          c_dirty_stop = 0;
  int          c_stream = 0;
  int          c_bad_sec = -1;
  logic [7:0]  c_r2 = 8'h00;
  int          c_pre = 0;

  logic [7:0]  mq[$];
  logic [7:0]  fr[6];
  int          fi = 0;
  logic [5:0]  log_idx[$];
  logic [31:0] log_arg[$];
  logic        pend = 1'b0;
  logic [7:0]  resp = 8'hFF;

  function automatic logic [7:0] pat(int sec, int i);
    int v;
    v = sec * 3 + i + (i / 256) * 5;
    return v[7:0];
  endfunction

  function automatic logic [15:0] sec_crc(int sec);
    logic [15:0] c;
    logic [7:0]  d;
    logic        fb;
    c = 16'h0000;
    for (int i = 0; i < 512; i++) begin
      d = pat(sec, i);
      for (int b = 7; b >= 0; b--) begin
        fb = c[15] ^ d[b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic push_fill(input int n);
    for (int i = 0; i < n; i++) mq.push_back(8'hFF);
  endtask

  task automatic push_sector(input int sec, input bit bad);
    logic [15:0] c;
    push_fill(4);
    mq.push_back(8'hFE);
    for (int i = 0; i < 512; i++) mq.push_back(pat(sec, i));
    c = sec_crc(sec);
    if (bad) c = c ^ 16'h0001;
    mq.push_back(c[15:8]);
    mq.push_back(c[7:0]);
  endtask

  task automatic card_cmd();
    logic [5:0]  idx;
    logic [31:0] arg;
    int          n;
    idx = fr[0][5:0];
    arg = {fr[1], fr[2], fr[3], fr[4]};
    log_idx.push_back(idx);
    log_arg.push_back(arg);
    if (c_mute) return;
    case (idx)
      6'd23: begin
        push_fill(c_ncr);
        if (c_rej23) mq.push_back(8'h04);
        else begin mq.push_back(8'h00); c_pre = int'(arg); end
      end
      6'd18: begin
        push_fill(c_ncr);
        mq.push_back(8'h00);
        n = (c_pre != 0) ? c_pre : c_stream;
        c_pre = 0;
        for (int s = 0; s < n; s++) push_sector(int'(arg) + s, s == c_bad_sec);
      end
      6'd12: begin
        if (c_dirty_stop && mq.size() > 0) begin
          mq.delete();
          mq.push_back(8'hFF);
          mq.push_back(8'h5A);
          mq.push_back(8'h3C);
        end else begin
          mq.delete();
          mq.push_back(8'hFF);
          push_fill(c_ncr);
          mq.push_back(8'h00);
        end
      end
      6'd13: begin
        push_fill(c_ncr);
        mq.push_back(8'h00);
        mq.push_back(c_r2);
      end
      default: ;
    endcase
  endtask

  // byte-exchange responder: 3 cycles per byte
  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; xfer_ack <= 1'b0; mq.delete(); fi = 0;
    end else begin
      logic [7:0] r;
      xfer_ack <= 1'b0;
      if (cs_n) begin mq.delete(); fi = 0; end
      if (pend) begin
        xfer_ack <= 1'b1; xfer_rx <= resp; pend <= 1'b0;
      end else if (xfer_req && !xfer_ack) begin
        if (cs_n) r = 8'hFF;
        else begin
          r = (mq.size() > 0) ? mq.pop_front() : 8'hFF;
          if (fi == 0 && xfer_tx[7:6] == 2'b01) begin fr[0] = xfer_tx; fi = 1; end
          else if (fi > 0) begin
            fr[fi] = xfer_tx; fi++;
            if (fi == 6) begin fi = 0; card_cmd(); end
          end
        end
        resp <= r; pend <= 1'b1;
      end
    end
  end

  // ---------------- expected output stream ----------------
  logic [7:0] exp_q[$];
  bit         exp_last_on = 0;
  int         cs_bounce = 0;
  logic       cs_prev = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && cs_n && !cs_prev) cs_bounce++;
      cs_prev = cs_n;
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(0, "R6 unexpected byte", rd_data, 0);
        else begin
          logic [7:0] e;
          bit         lst;
          e = exp_q.pop_front();
          lst = exp_last_on && (exp_q.size() == 0);
          chk(rd_data == e, "R6 data byte", rd_data, e);
          chk(rd_last == lst, "R6 last strobe", rd_last, lst);
        end
      end else if (rd_last) chk(0, "R6 last without valid", 1, 0);
    end
  end

  logic [5:0]  ex_idx[$];
  logic [31:0] ex_arg[$];

  task automatic expect_data(input int sec, input int nsec, input bit last_on);
    exp_q.delete();
    for (int s = 0; s < nsec; s++)
      for (int i = 0; i < 512; i++) exp_q.push_back(pat(sec + s, i));
    exp_last_on = last_on;
  endtask

  task automatic do_read(input string tag, input int sec, input int cnt, input bit poke,
                         input bit exp_err, input logic [1:0] exp_warn);
    bit got;
    log_idx.delete(); log_arg.delete(); cs_bounce = 0;
    @(negedge clk);
    start = 1'b1; start_sector = 32'(sec); sector_count = 16'(cnt);
    @(negedge clk);
    start = 1'b0;
    got = 0;
    for (int i = 0; i < 40000 && !got; i++) begin
      if (done) got = 1;
      else begin
        if (poke && i == 300) begin start = 1'b1; start_sector = 32'd999; end
        if (poke && i == 301) start = 1'b0;
        @(negedge clk);
      end
    end
    chk(got, {tag, " watchdog/done"}, got, 1);
    chk(!busy, {tag, " R13 idle at done"}, busy, 0);
    chk(err == exp_err, {tag, " err"}, err, exp_err);
    chk(warnings == exp_warn, {tag, " warnings"}, warnings, exp_warn);
    chk(exp_q.size() == 0, {tag, " R6 bytes missing"}, exp_q.size(), 0);
    chk(log_idx.size() == ex_idx.size(), {tag, " R2 command count"}, log_idx.size(), ex_idx.size());
    for (int k = 0; k < ex_idx.size() && k < log_idx.size(); k++) begin
      chk(log_idx[k] == ex_idx[k], {tag, " R2 command index"}, log_idx[k], ex_idx[k]);
      chk(log_arg[k] == ex_arg[k], {tag, " R2 command argument"}, log_arg[k], ex_arg[k]);
    end
    @(negedge clk);
    chk(!done, {tag, " R13 done one cycle"}, done, 0);
    chk(cs_n, {tag, " R1 cs idle high"}, cs_n, 1);
  endtask

  task automatic ex(input logic [5:0] i, input logic [31:0] a);
    ex_idx.push_back(i); ex_arg.push_back(a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(warnings == 2'b00, "R1 reset warnings", warnings, 0);
    chk(xfer_req == 1'b0 && rd_valid == 1'b0, "R1 reset strobes", xfer_req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 counted read, turnaround 7 fillers (R3), start ignored while busy (R12)
    c_ncr = 7; c_rej23 = 0;
    ex_idx.delete(); ex_arg.delete();
    ex(23, 3); ex(18, 100); ex(13, 0);
    expect_data(100, 3, 1);
    do_read("R4 counted", 100, 3, 1, 0, 2'b00);
    chk(cs_bounce == 0, "R4 no cs bounce", cs_bounce, 0);

    // R11 zero count
    ex_idx.delete(); ex_arg.delete();
    expect_data(0, 0, 0);
    do_read("R11 zero count", 50, 0, 0, 0, 2'b00);

    // R5 CMD23 rejected, fallback in same read
    c_ncr = 2; c_rej23 = 1; c_stream = 3;
    ex_idx.delete(); ex_arg.delete();
    ex(23, 2); ex(18, 7); ex(12, 0); ex(13, 0);
    expect_data(7, 2, 1);
    do_read("R5 reject", 7, 2, 0, 0, 2'b01);

    // R5 later read skips CMD23
    c_stream = 2;
    ex_idx.delete(); ex_arg.delete();
    ex(18, 9); ex(12, 0); ex(13, 0);
    expect_data(9, 1, 1);
    do_read("R5 sticky", 9, 1, 0, 0, 2'b01);

    // R9 card streaming when stopped
    c_dirty_stop = 1; c_stream = 3;
    ex_idx.delete(); ex_arg.delete();
    ex(18, 20); ex(12, 0); ex(13, 0);
    expect_data(20, 2, 1);
    do_read("R9 recovery", 20, 2, 0, 0, 2'b11);
    chk(cs_bounce > 0, "R9 cs released", cs_bounce, 1);

    // R8 CRC mismatch on second sector
    c_dirty_stop = 0; c_stream = 4; c_bad_sec = 1;
    ex_idx.delete(); ex_arg.delete();
    ex(18, 40); ex(12, 0);
    expect_data(40, 2, 0);
    do_read("R8 crc", 40, 3, 0, 1, 2'b11);
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R13 err held", err, 1);

    // R7 no start token
    c_bad_sec = -1; c_stream = 0;
    ex_idx.delete(); ex_arg.delete();
    ex(18, 60); ex(12, 0);
    expect_data(0, 0, 0);
    do_read("R7 token timeout", 60, 2, 0, 1, 2'b11);

    // R10 nonzero status
    c_stream = 2; c_r2 = 8'h20;
    ex_idx.delete(); ex_arg.delete();
    ex(18, 70); ex(12, 0); ex(13, 0);
    expect_data(70, 1, 1);
    do_read("R10 status", 70, 1, 0, 1, 2'b11);

    // R3 silent card
    c_r2 = 8'h00; c_mute = 1;
    ex_idx.delete(); ex_arg.delete();
    ex(18, 80);
    expect_data(0, 0, 0);
    do_read("R3 mute", 80, 1, 0, 1, 2'b11);

    // R3 turnaround of 8 fillers exceeds poll limit
    c_mute = 0; c_ncr = 8;
    ex_idx.delete(); ex_arg.delete();
    ex(18, 90);
    expect_data(0, 0, 0);
    do_read("R3 ncr limit", 90, 1, 0, 1, 2'b11);

    // R13 clean read clears err
    c_ncr = 3;
    ex_idx.delete(); ex_arg.delete();
    ex(18, 5); ex(12, 0); ex(13, 0);
    expect_data(5, 1, 1);
    do_read("R13 err cleared", 5, 1, 0, 0, 2'b11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule